// File: doc/BRIEF.md
# Event Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from the receive path, the transmit path, the link monitor, the statistics counters and the bus-error logic into a 32-bit pending-status register. A mask register selects which pending bits may raise the single interrupt line. A one-bit global enable gates that line. The handler reads the status register and acknowledges events. Ones written back clear bits in the low half. Bits in the high half clear when the status register is read. Two summary outputs group the pending, unmasked events into a normal class and an abnormal class, so the handler can choose its path without decoding every bit.

Software reaches the block through a simple register port. It gives a 2-bit select, write and read strobes, 32-bit write data and combinational read data. The event sources drive `evt_i` with pulses that are one cycle long.

Top module: `irq_evt_ctrl`

## Requirements
- R1: After reset, the status, mask and enable registers all read zero, and `irq_o`, `norm_sum_o` and `abn_sum_o` are low.
- R2: An `evt_i` pulse sets the matching status bit on the next clock edge. The bit stays set until it is cleared. Only these positions exist: bits 0..11, 13, 14, 20..23, 24 and 25 (mask 0x03F06FFF). A pulse at any other position leaves the status reading zero there.
- R3: A write to the status register clears each bit in [15:0] where the write data holds a one. Status bits [31:16] are unaffected by any write.
- R4: A read of the status register returns the value held before the read. Status bits [31:16] are zero after that read unless a new event sets them in the same cycle. Bits [15:0] are not changed by a read.
- R5: An event in the same cycle as a clear of the same bit wins, and the bit stays set.
- R6: `irq_o` is a level output. It is high exactly while enable bit 0 is one and status AND mask is nonzero.
- R7: The mask register reads back all 32 written bits. The enable register keeps only write-data bit 0, and its bits [31:1] read zero.
- R8: `norm_sum_o` is high while status AND mask has any bit in 0x00000251. `abn_sum_o` is high while status AND mask has any bit in 0x0000CD20. Neither depends on the enable.
- R9: Select code 0 addresses status, 1 mask, 2 enable. Select code 3 reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per status position |
| sel_i | input | 2 | Register select (0 status, 1 mask, 2 enable, 3 none) |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (read side effects on status) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Interrupt request, level |
| norm_sum_o | output | 1 | Normal-class pending summary |
| abn_sum_o | output | 1 | Abnormal-class pending summary |

## Verification
An all-ones event burst shows which positions exist and which do not. Partial write-back patterns show the low-half clear apart from the read clear of the high half. A write and a pulse on the same bit in the same cycle shows which of the two has priority. Mask and enable settings are stepped one at a time so each gating term of the interrupt is seen on its own. Single events from each class show that the two summaries are separate.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned W1C_W  = 16;
  localparam logic [STAT_W-1:0] IMPL_BITS = 32'h03F0_6FFF;
  localparam logic [STAT_W-1:0] NORM_GRP  = 32'h0000_0251;
  localparam logic [STAT_W-1:0] ABN_GRP   = 32'h0000_CD20;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank #(
  parameter int unsigned DW = 32,
  parameter int unsigned W1C_W = 16,
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic          wr_stat_i,
  input  logic          rd_stat_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] stat_q;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic clr;
      if (i < W1C_W) begin : g_w1c
        assign clr = wr_stat_i & wdata_i[i];
      end else begin : g_rc
        assign clr = rd_stat_i;
      end
      // set has priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_q[i] <= 1'b0;
        else         stat_q[i] <= evt_i[i] | (stat_q[i] & ~clr);
      end
    end else begin : g_void
      assign stat_q[i] = 1'b0;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_mask_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o,
  output logic          en_o
);
  logic [DW-1:0] mask_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i;
      if (wr_en_i)   en_q   <= wdata_i[0];
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_out_logic.sv
module irq_out_logic #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] NORM = '0,
  parameter logic [DW-1:0] ABN  = '0
) (
  input  logic [DW-1:0] stat_i,
  input  logic [DW-1:0] mask_i,
  input  logic          en_i,
  output logic          irq_o,
  output logic          norm_o,
  output logic          abn_o
);
  logic [DW-1:0] pend;

  always_comb begin
    pend   = stat_i & mask_i;
    irq_o  = en_i & (|pend);
    norm_o = |(pend & NORM);
    abn_o  = |(pend & ABN);
  end
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [1:0]        sel_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              norm_sum_o,
  output logic              abn_sum_o
);
  reg_sel_e          sel;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] mask_q;
  logic              en_q;
  logic              wr_stat, rd_stat, wr_mask, wr_en;

  assign sel     = reg_sel_e'(sel_i);
  assign wr_stat = wr_i & (sel == SEL_STAT);
  assign rd_stat = rd_i & (sel == SEL_STAT);
  assign wr_mask = wr_i & (sel == SEL_MASK);
  assign wr_en   = wr_i & (sel == SEL_EN);

  irq_stat_bank #(
    .DW(STAT_W), .W1C_W(W1C_W), .IMPL(IMPL_BITS)
  ) u_stat (
    .clk_i, .rst_ni, .evt_i,
    .wr_stat_i(wr_stat), .rd_stat_i(rd_stat), .wdata_i,
    .stat_o(status_q)
  );

  irq_cfg_regs #(.DW(STAT_W)) u_cfg (
    .clk_i, .rst_ni,
    .wr_mask_i(wr_mask), .wr_en_i(wr_en), .wdata_i,
    .mask_o(mask_q), .en_o(en_q)
  );

  irq_out_logic #(
    .DW(STAT_W), .NORM(NORM_GRP), .ABN(ABN_GRP)
  ) u_out (
    .stat_i(status_q), .mask_i(mask_q), .en_i(en_q),
    .irq_o, .norm_o(norm_sum_o), .abn_o(abn_sum_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = status_q;
      SEL_MASK: rdata_o = mask_q;
      SEL_EN:   rdata_o = {{(STAT_W-1){1'b0}}, en_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_evt_ctrl_chk.sv
module irq_evt_ctrl_chk
  import irq_evt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] evt_i,
  input logic [1:0]        sel_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [STAT_W-1:0] wdata_i,
  input logic [STAT_W-1:0] status_i,
  input logic [STAT_W-1:0] mask_i,
  input logic              en_i,
  input logic              irq_i,
  input logic              norm_i,
  input logic              abn_i
);
  p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 2'd0) |=>
      ((status_i & $past(wdata_i & 32'h0000_FFFF & ~evt_i)) == '0));

  p_hi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && sel_i == 2'd0) |=>
      ((status_i[31:16] & $past(status_i[31:16])) == $past(status_i[31:16])));

  p_rd_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel_i == 2'd0) |=>
      ((status_i[31:16] & ~$past(evt_i[31:16])) == '0));

  p_evt_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & IMPL_BITS)) |=>
      ((status_i & $past(evt_i & IMPL_BITS)) == $past(evt_i & IMPL_BITS)));

  p_no_void_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i & ~IMPL_BITS) == '0);

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_i);

  p_irq_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_i & mask_i) == '0) |-> (!irq_i && !norm_i && !abn_i));

  p_sum_pend_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (norm_i || abn_i) && en_i |-> irq_i);
endmodule

bind irq_evt_ctrl irq_evt_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .sel_i(sel_i),
  .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
  .status_i(status_q), .mask_i(mask_q), .en_i(en_q),
  .irq_i(irq_o), .norm_i(norm_sum_o), .abn_i(abn_sum_o)
);

// File: tb/sim_irq_evt_ctrl.sv
`timescale 1ns/1ps
module sim_irq_evt_ctrl;
  localparam logic [31:0] IMPL = 32'h03F0_6FFF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] evt = '0;
  logic [1:0]  sel = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, norm, abn;

  int total = 0;
  int bad = 0;
  logic [31:0] exp_st = '0;

  always #10 clk = ~clk;

  irq_evt_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt), .sel_i(sel),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .norm_sum_o(norm), .abn_sum_o(abn)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [31:0] ev);
    @(negedge clk); evt = ev;
    @(negedge clk); evt = '0;
    exp_st = exp_st | (ev & IMPL);
  endtask

  task automatic wr_reg(logic [1:0] s, logic [31:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (s == 2'd0) exp_st = exp_st & ~(d & 32'h0000_FFFF);
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); sel = s; rd = 1'b1;
    #2 v = rdata;
    @(negedge clk); rd = 1'b0;
    if (s == 2'd0) exp_st = exp_st & 32'h0000_FFFF;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd_reg(2'd0, v); chk("R1 status", v, '0);
    rd_reg(2'd1, v); chk("R1 mask", v, '0);
    rd_reg(2'd2, v); chk("R1 enable", v, '0);
    chk("R1 outputs", {29'd0, irq, norm, abn}, '0);
  endtask

  task automatic t_latch();
    logic [31:0] v;
    pulse(32'hFFFF_FFFF);
    rd_reg(2'd0, v); chk("R2 implemented bits", v, 32'h03F0_6FFF);
    rd_reg(2'd0, v); chk("R4 high half cleared by read", v, 32'h0000_6FFF);
    rd_reg(2'd0, v); chk("R4 low half kept by read", v, exp_st);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr_reg(2'd0, 32'h0000_00F0);
    rd_reg(2'd0, v); chk("R3 partial clear", v, 32'h0000_6F0F);
    pulse(32'h0010_0000);
    wr_reg(2'd0, 32'hFFFF_0000);
    rd_reg(2'd0, v); chk("R3 high half ignores write", v, 32'h0010_6F0F);
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, v); chk("R3 full clear", v, '0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk); sel = 2'd0; wdata = 32'h0000_0003; wr = 1'b1; evt = 32'h0000_0001;
    @(negedge clk); wr = 1'b0; evt = '0;
    rd_reg(2'd0, v); chk("R5 event beats clear", v, 32'h0000_0001);
    pulse(32'h0100_0000);
    @(negedge clk); sel = 2'd0; rd = 1'b1; evt = 32'h0100_0000;
    @(negedge clk); rd = 1'b0; evt = '0;
    rd_reg(2'd0, v); chk("R5 event beats read clear", v, 32'h0100_0001);
    wr_reg(2'd0, 32'h0000_FFFF);
    rd_reg(2'd0, v); exp_st = '0;
  endtask

  task automatic t_irq();
    wr_reg(2'd1, 32'h0000_0001);
    pulse(32'h0000_0001);
    #1 chk("R6 irq gated by enable", {31'd0, irq}, 0);
    wr_reg(2'd2, 32'h0000_0001);
    #1 chk("R6 irq asserted", {31'd0, irq}, 1);
    repeat (3) @(negedge clk);
    #1 chk("R6 irq level held", {31'd0, irq}, 1);
    wr_reg(2'd1, 32'h0000_0000);
    #1 chk("R6 irq masked off", {31'd0, irq}, 0);
    wr_reg(2'd1, 32'h0000_0001);
    wr_reg(2'd0, 32'h0000_0001);
    #1 chk("R6 irq drops on clear", {31'd0, irq}, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr_reg(2'd1, 32'hA5C3_0F69);
    rd_reg(2'd1, v); chk("R7 mask readback", v, 32'hA5C3_0F69);
    wr_reg(2'd2, 32'hFFFF_FFFE);
    rd_reg(2'd2, v); chk("R7 enable bit0 only", v, 32'h0);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, v); chk("R7 enable set", v, 32'h1);
    wr_reg(2'd3, 32'hFFFF_FFFF);
    rd_reg(2'd3, v); chk("R9 select 3 reads zero", v, 32'h0);
    rd_reg(2'd1, v); chk("R9 select 3 write ignored", v, 32'hA5C3_0F69);
  endtask

  task automatic t_sum();
    wr_reg(2'd2, 32'h0);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    pulse(32'h0000_0040);
    #1 chk("R8 normal only", {30'd0, norm, abn}, 32'h2);
    pulse(32'h0000_0020);
    #1 chk("R8 both classes", {30'd0, norm, abn}, 32'h3);
    wr_reg(2'd1, 32'h0000_0020);
    #1 chk("R8 mask selects abnormal", {30'd0, norm, abn}, 32'h1);
    wr_reg(2'd1, 32'h0000_0002);
    #1 chk("R8 non-group bit no summary", {30'd0, norm, abn}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_latch();
    t_w1c();
    t_race();
    t_irq();
    t_cfg();
    t_sum();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule